// File: doc/BRIEF.md
# Playback Byte Assembler

This block gathers programmed-I/O playback writes into complete audio samples. Software writes the 8-bit, write-only playback data port once per byte. Each accepted byte goes into the next lane of the sample being built, starting at the least significant lane. The sample length is set by a bytes-per-sample input and runs from one byte (8-bit mono) to four bytes (16-bit stereo).

When every byte of the sample is in place, the block raises a completion flag and drops any further port writes. A read of the status register rearms the block. If the sample was complete at that read, the assembled word is handed to the converter FIFO with a single-cycle push strobe. If the sample was still partial, the read discards it and no push occurs. In both cases the next write lands in lane 0 again.

Top module: `pb_byte_asm`

## Requirements
- R1: While `rst_ni` is low, and in the first cycle after it is released, `push_o` is 0, `full_o` is 0 and `sample_o` is all zeros. No bytes are held.
- R2: Byte lanes are filled in ascending order. The k-th byte accepted since the last rearm (k counted from 0) goes to bits [8k+7:8k] of the sample.
- R3: `bps_i` selects the sample length as bytes-per-sample minus one (0 = 1 byte, up to 3 = 4 bytes). `full_o` is 1 exactly when the number of bytes accepted since the last rearm is at least `bps_i`+1.
- R4: A write presented while `full_o` is 1 is dropped. It changes neither the stored sample nor the value later pushed.
- R5: A status read seen on a clock edge while `full_o` is 1 makes `push_o` 1 for exactly the following cycle. `push_o` is never 1 at any other time.
- R6: In the cycle `push_o` is 1, `sample_o` carries the assembled bytes, with lanes that were never written reading as zero. `sample_o` keeps that value until the next push.
- R7: A status read while `full_o` is 0 discards the partial sample and resets the lane pointer. It causes no push.
- R8: When a write and a status read fall on the same edge, the read takes effect and the write byte is discarded.
- R9: After any status read, `full_o` is 0 and the next accepted write goes to lane 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Playback data port write strobe |
| wr_data_i | input | 8 | Byte written to the playback data port |
| bps_i | input | 2 | Bytes per sample minus one |
| stat_rd_i | input | 1 | Status register read strobe |
| sample_o | output | 32 | Last pushed sample word |
| push_o | output | 1 | One-cycle push toward the converter FIFO |
| full_o | output | 1 | All bytes of the current sample received |

## Verification
The main path is tried at every sample length from one to four bytes, with distinct byte values so that a byte in the wrong lane shows up in the pushed word.

Extra writes after completion test whether the saturation really drops bytes. Status reads on a half-filled sample check that a partial sample is discarded without a push, and that the next write starts again at lane 0.

A write that coincides with a status read checks the priority between the two strobes. Changing `bps_i` on a partially filled sample checks that the completion flag follows the byte count. Bursts of back-to-back rearms with random strobes confirm that the push never lasts longer than one cycle.

// File: rtl/pb_asm_pkg.sv
package pb_asm_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/pb_ptr.sv
module pb_ptr #(
  parameter int unsigned MAX_BYTES = 4,
  parameter int unsigned CNT_W     = 3,
  parameter int unsigned BPS_W     = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic             rd_i,
  input  logic [BPS_W-1:0] bps_i,
  output logic [CNT_W-1:0] ptr_o,
  output logic             full_o,
  output logic             accept_o
);
  logic [CNT_W-1:0] ptr_q;
  logic [CNT_W-1:0] n_bytes;

  assign n_bytes  = CNT_W'(bps_i) + CNT_W'(1);
  assign full_o   = (ptr_q >= n_bytes);
  // read wins over a coincident write
  assign accept_o = wr_en_i && !rd_i && !full_o;
  assign ptr_o    = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ptr_q <= '0;
    else if (rd_i)     ptr_q <= '0;
    else if (accept_o) ptr_q <= ptr_q + CNT_W'(1);
  end
endmodule

// File: rtl/pb_lanes.sv
module pb_lanes
  import pb_asm_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 4,
  parameter int unsigned CNT_W     = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        clr_i,
  input  logic                        accept_i,
  input  logic [CNT_W-1:0]            ptr_i,
  input  byte_t                       data_i,
  output logic [MAX_BYTES*BYTE_W-1:0] word_o
);
  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
    byte_t lane_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                lane_q <= '0;
      else if (clr_i)                             lane_q <= '0;
      else if (accept_i && ptr_i == CNT_W'(g))    lane_q <= data_i;
    end
    assign word_o[g*BYTE_W +: BYTE_W] = lane_q;
  end
endmodule

// File: rtl/pb_out.sv
module pb_out #(
  parameter int unsigned SAMPLE_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                push_req_i,
  input  logic [SAMPLE_W-1:0] word_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                push_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_o <= '0;
      push_o   <= 1'b0;
    end else begin
      push_o <= push_req_i;
      if (push_req_i) sample_o <= word_i;
    end
  end
endmodule

// File: rtl/pb_byte_asm.sv
module pb_byte_asm
  import pb_asm_pkg::*;
#(
  parameter int unsigned MAX_BYTES = 4,
  localparam int unsigned SAMPLE_W = MAX_BYTES * BYTE_W,
  localparam int unsigned CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int unsigned BPS_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [BYTE_W-1:0]   wr_data_i,
  input  logic [BPS_W-1:0]    bps_i,
  input  logic                stat_rd_i,
  output logic [SAMPLE_W-1:0] sample_o,
  output logic                push_o,
  output logic                full_o
);
  logic [CNT_W-1:0]    ptr;
  logic                accept;
  logic [SAMPLE_W-1:0] word;

  pb_ptr #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W), .BPS_W(BPS_W)) u_ptr (
    .clk_i, .rst_ni,
    .wr_en_i,
    .rd_i    (stat_rd_i),
    .bps_i,
    .ptr_o   (ptr),
    .full_o,
    .accept_o(accept)
  );

  pb_lanes #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_lanes (
    .clk_i, .rst_ni,
    .clr_i   (stat_rd_i),
    .accept_i(accept),
    .ptr_i   (ptr),
    .data_i  (wr_data_i),
    .word_o  (word)
  );

  pb_out #(.SAMPLE_W(SAMPLE_W)) u_out (
    .clk_i, .rst_ni,
    .push_req_i(stat_rd_i && full_o),
    .word_i    (word),
    .sample_o,
    .push_o
  );
endmodule

// File: rtl/pb_byte_asm_chk.sv
module pb_byte_asm_chk #(
  parameter int unsigned SAMPLE_W = 32
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                stat_rd_i,
  input logic [SAMPLE_W-1:0] sample_o,
  input logic                push_o,
  input logic                full_o
);
  AST_PUSH_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |=> !push_o); // R5
  AST_PUSH_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> $past(stat_rd_i && full_o)); // R5
  AST_REARM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i |=> !full_o); // R9
  AST_SAMPLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !push_o |-> $stable(sample_o)); // R6
  AST_NO_PUSH_PARTIAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_rd_i && !full_o) |=> !push_o); // R7
endmodule

bind pb_byte_asm pb_byte_asm_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .stat_rd_i(stat_rd_i),
  .sample_o (sample_o),
  .push_o   (push_o),
  .full_o   (full_o)
);

// File: tb/pb_byte_asm_tb_top.sv
`timescale 1ns/1ps
module pb_byte_asm_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [1:0]  bps = '0;
  logic        stat_rd = 1'b0;
  logic [31:0] sample;
  logic        push;
  logic        full;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int          m_cnt = 0;
  logic [31:0] m_acc = '0;
  logic [31:0] m_sample = '0;
  bit          m_push = 0;

  always #5 clk = ~clk;

  pb_byte_asm dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .bps_i(bps), .stat_rd_i(stat_rd),
    .sample_o(sample), .push_o(push), .full_o(full)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit exp_full;
    exp_full = (m_cnt >= int'(bps) + 1);
    chk("R5", "push_o", 32'(push), 32'(m_push));
    chk("R6", "sample_o", sample, m_sample);
    chk("R3", "full_o", 32'(full), 32'(exp_full));
  endtask

  // drive, clock, update model, compare at negedge
  task automatic step(input bit wr, input logic [7:0] d, input bit rd);
    wr_en = wr; wr_data = d; stat_rd = rd;
    @(posedge clk);
    m_push = 0;
    if (rd) begin // R8: read wins
      if (m_cnt >= int'(bps) + 1) begin
        m_push = 1;
        m_sample = m_acc;
      end
      m_cnt = 0;
      m_acc = '0;
    end else if (wr && m_cnt < int'(bps) + 1) begin // R4 drop when full
      m_acc[m_cnt*8 +: 8] = d; // R2
      m_cnt++;
    end
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "push_o", 32'(push), 32'd0);
    chk("R1", "full_o", 32'(full), 32'd0);
    chk("R1", "sample_o", sample, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    compare_all();

    // R2 R3 R5 R6: each sample length, distinct bytes, extra writes dropped (R4)
    for (int n = 0; n < 4; n++) begin
      bps = 2'(n);
      for (int k = 0; k < n + 3; k++) step(1, 8'(8'hA0 + 8'(n * 16) + 8'(k)), 0);
      step(0, 8'h00, 1);
      step(0, 8'h00, 0);
    end

    // R7: partial sample discarded, no push; R9 restart at lane 0
    bps = 2'd3;
    step(1, 8'h11, 0);
    step(1, 8'h22, 0);
    step(0, 8'h00, 1);
    for (int k = 0; k < 4; k++) step(1, 8'(8'h31 + 8'(k)), 0);
    step(0, 8'h00, 1);

    // R8: coincident write and read
    bps = 2'd1;
    step(1, 8'h5A, 0);
    step(1, 8'h6B, 0);
    step(1, 8'hEE, 1);
    step(1, 8'h77, 0);
    step(1, 8'h88, 1); // partial, write discarded
    step(1, 8'h99, 0);
    step(1, 8'hAA, 0);
    step(0, 8'h00, 1);

    // R3: lowering bps on a partial sample makes it full
    bps = 2'd3;
    step(1, 8'hC1, 0);
    step(1, 8'hC2, 0);
    bps = 2'd0;
    step(1, 8'hC3, 0);
    step(0, 8'h00, 1);
    step(0, 8'h00, 1); // back-to-back rearm, no second push

    // random strobes
    for (int i = 0; i < 400; i++) begin
      bps = 2'($urandom_range(0, 3));
      step(1'($urandom_range(0, 1)), 8'($urandom), ($urandom_range(0, 3) == 0));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule